// File: doc/BRIEF.md
# Host Adapter Interrupt and Command Front End

This block is the byte-wide register face of a parallel-bus host adapter. The host reaches it through a small address window. It decodes writes to a command register and runs the commands that act only on registers. It holds the interrupt-reason, status, sequence-step and FIFO-flag registers, three plain configuration registers and three transfer-count bytes. It drives one level-sensitive interrupt line. The bus phase engine and the data mover sit outside the block. They report each outcome through a one-cycle completion event. That event loads the reason, status, step and flag values and raises the interrupt.

The host clears an interrupt by reading the interrupt-reason register. That read returns the old reason and then clears the reason, the interrupt and the terminal-count status bit, and it sets the sequence step to "command done". The high transfer-count byte reads as a fixed identifier until the host writes that byte after a reset. A bit in configuration register 1 silences the interrupt that a bus reset would otherwise raise.

Register map by index: 0 count low, 1 count mid, 2 count high, 3 command (write-only), 4 status, 5 interrupt reason, 6 sequence step, 7 FIFO flags, 8 to 10 configuration 1 to 3. Indices 4 to 7 are read-only. Indices 11 to 15 read as zero and ignore writes.

Top module: `hfe_front_end`

## Requirements
- R1: The register index is the bus address shifted right by REG_SHIFT; address bits beyond a 4-bit index select nothing. Byte reads and writes are accepted, and word writes (acc_word=1) are accepted using the low data byte. A word read returns 0 and has no side effect.
- R2: The irq output always equals status bit 7. Raising while bit 7 is already set leaves irq high and produces no new rising edge.
- R3: A byte read of index 5 returns the current reason. After it, the reason is 0, status bits 7 and 4 are 0, the sequence step is 4 and irq is low.
- R4: While rst is high, all registers clear, configuration 1 becomes 7, the identifier becomes visible again and irq goes low.
- R5: Command 0x02, or ext_reset high for a cycle, has the same effect as R4.
- R6: Command 0x03 loads reason 0x80. It raises irq only when bit 6 of configuration 1 is 0.
- R7: Command 0x01 loads reason 0x08, clears the sequence step and the FIFO flags, and does not raise irq.
- R8: Command 0x12 loads reason 0x20, clears the sequence step and the FIFO flags, and raises irq.
- R9: Command 0x45 clears the reason and raises irq. Command 0x44 clears the reason and leaves irq unchanged.
- R10: Command 0x18 sets status to bit 4 alone, keeping bit 7 as it was. It loads reason 0x08, clears the sequence step and does not raise irq.
- R11: Index 2 reads the CHIP_ID parameter until index 2 is written after a reset, and the written value after that. A write to any of indices 0 to 2 clears status bit 4.
- R12: A completion event loads reason, sequence step and FIFO flags from its inputs and status bits 6 to 0 from evt_status, and it raises irq.
- R13: Command bit 7 is ignored when decoding. Unknown command codes, and writes to read-only or undefined indices, change no state.
- R14: Configuration registers 1 to 3 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| ext_reset | input | 1 | External reset request, level high |
| bus_addr | input | ADDR_W | Host byte address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| acc_word | input | 1 | Access is 32 bits wide (0 = byte) |
| wr_data | input | 8 | Write data (low byte lane) |
| rd_data | output | 8 | Read data, valid in the cycle rd_en is high |
| evt_valid | input | 1 | Completion event strobe |
| evt_intr | input | 8 | Reason value carried by the event |
| evt_status | input | 8 | Status value carried by the event (bit 7 ignored) |
| evt_seq | input | 8 | Sequence-step value carried by the event |
| evt_flags | input | 8 | FIFO-flag value carried by the event |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench targets the destructive reason read. It checks that the read returns the old value and then clears the reason, the interrupt and terminal count, and loads step 4. A design that cleared before returning would hand the host zero. The bench raises a second event while the interrupt is pending and counts rising edges: a re-raising design would give two. It masks the bus-reset report and checks that irq stays low. It shows that word reads, unknown commands and writes to read-only indices leave the reason and status intact. It checks that the identifier comes back after a soft reset, which a design that forgot the written-once flag would fail.

// File: rtl/hfe_pkg.sv
package hfe_pkg;

    // Register indices after the address shift.
    localparam int IDX_W = 4;
    localparam logic [IDX_W-1:0] IDX_CNT_LO  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_CNT_MID = 4'd1;
    localparam logic [IDX_W-1:0] IDX_CNT_HI  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_CMD     = 4'd3;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_INTR    = 4'd5;
    localparam logic [IDX_W-1:0] IDX_SEQ     = 4'd6;
    localparam logic [IDX_W-1:0] IDX_FLAGS   = 4'd7;
    localparam logic [IDX_W-1:0] IDX_CONF1   = 4'd8;
    localparam logic [IDX_W-1:0] IDX_CONF2   = 4'd9;
    localparam logic [IDX_W-1:0] IDX_CONF3   = 4'd10;

    // Command codes, compared with bit 7 masked off.
    localparam logic [7:0] OP_NOP     = 8'h00;
    localparam logic [7:0] OP_FLUSH   = 8'h01;
    localparam logic [7:0] OP_SRESET  = 8'h02;
    localparam logic [7:0] OP_BRESET  = 8'h03;
    localparam logic [7:0] OP_MSGOK   = 8'h12;
    localparam logic [7:0] OP_PAD     = 8'h18;
    localparam logic [7:0] OP_SELON   = 8'h44;
    localparam logic [7:0] OP_SELOFF  = 8'h45;
    localparam logic [7:0] OP_MASK    = 8'h7F;

    // Reason codes.
    localparam logic [7:0] WHY_DONE   = 8'h08;
    localparam logic [7:0] WHY_DISC   = 8'h20;
    localparam logic [7:0] WHY_BUSRST = 8'h80;

    // Status bits and other constants.
    localparam int         ST_INT       = 7;
    localparam int         ST_TC        = 4;
    localparam logic [7:0] INT_MASK     = 8'h80;
    localparam logic [7:0] TC_MASK      = 8'h10;
    localparam logic [7:0] SEQ_DONE     = 8'h04;
    localparam logic [7:0] CONF1_RESET  = 8'h07;
    localparam int         RPT_OFF_BIT  = 6;

    typedef struct packed {
        logic       known;
        logic       soft_reset;
        logic       load_intr;
        logic [7:0] intr_val;
        logic       clr_seq;
        logic       clr_flags;
        logic       raise;
        logic       raise_unmasked;
        logic       pad;
    } cmd_act_t;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] intr;
        logic [7:0] seq;
        logic [7:0] flags;
        logic [7:0] cnt_lo;
        logic [7:0] cnt_mid;
        logic [7:0] cnt_hi;
        logic [7:0] conf1;
        logic [7:0] conf2;
        logic [7:0] conf3;
        logic       hi_written;
    } hfe_regs_t;

    function automatic hfe_regs_t regs_reset();
        hfe_regs_t r;
        r       = '0;
        r.conf1 = CONF1_RESET;
        return r;
    endfunction

    function automatic cmd_act_t decode_cmd(logic [7:0] cb);
        cmd_act_t a;
        a = '0;
        a.known = 1'b1;
        case (cb & OP_MASK)
            OP_NOP:    ;
            OP_SRESET: a.soft_reset = 1'b1;
            OP_FLUSH: begin
                a.load_intr = 1'b1; a.intr_val = WHY_DONE;
                a.clr_seq = 1'b1;   a.clr_flags = 1'b1;
            end
            OP_BRESET: begin
                a.load_intr = 1'b1; a.intr_val = WHY_BUSRST;
                a.raise_unmasked = 1'b1;
            end
            OP_MSGOK: begin
                a.load_intr = 1'b1; a.intr_val = WHY_DISC;
                a.clr_seq = 1'b1;   a.clr_flags = 1'b1;
                a.raise = 1'b1;
            end
            OP_PAD: begin
                a.load_intr = 1'b1; a.intr_val = WHY_DONE;
                a.clr_seq = 1'b1;   a.pad = 1'b1;
            end
            OP_SELON:  a.load_intr = 1'b1;
            OP_SELOFF: begin
                a.load_intr = 1'b1;
                a.raise = 1'b1;
            end
            default:   a.known = 1'b0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/hfe_addr_decode.sv
module hfe_addr_decode
    import hfe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int REG_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              acc_word,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              wr_go,
    output logic              rd_go
);
    logic [ADDR_W-1:0] shifted;
    logic              in_window;

    always_comb begin
        shifted   = bus_addr >> REG_SHIFT;
        in_window = ((shifted >> IDX_W) == '0);
        reg_idx   = shifted[IDX_W-1:0];
        wr_go     = wr_en && in_window;
        rd_go     = rd_en && !acc_word && in_window;
    end
endmodule

// File: rtl/hfe_cmd_decode.sv
module hfe_cmd_decode
    import hfe_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_act_t   act
);
    always_comb act = decode_cmd(cmd_byte);
endmodule

// File: rtl/hfe_reg_state.sv
module hfe_reg_state
    import hfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_reset,
    input  logic             wr_go,
    input  logic             rd_go,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [7:0]       wr_data,
    input  cmd_act_t         act,
    input  logic             evt_valid,
    input  logic [7:0]       evt_intr,
    input  logic [7:0]       evt_status,
    input  logic [7:0]       evt_seq,
    input  logic [7:0]       evt_flags,
    output hfe_regs_t        regs_q,
    output logic             irq_q
);
    hfe_regs_t nx;
    logic      cmd_hit, raise_cmd, rd_intr, do_reset, irq_nx;

    always_comb begin
        cmd_hit   = wr_go && (reg_idx == IDX_CMD) && act.known;
        raise_cmd = cmd_hit && (act.raise ||
                    (act.raise_unmasked && !regs_q.conf1[RPT_OFF_BIT]));
        rd_intr   = rd_go && (reg_idx == IDX_INTR);
        do_reset  = rst || ext_reset || (cmd_hit && act.soft_reset);
    end

    // Order inside a cycle: event, then reason read, then host write.
    always_comb begin
        nx = regs_q;
        if (evt_valid) begin
            nx.status = (regs_q.status & INT_MASK) | (evt_status & ~INT_MASK);
            nx.status[ST_INT] = 1'b1;
            nx.intr  = evt_intr;
            nx.seq   = evt_seq;
            nx.flags = evt_flags;
        end
        if (rd_intr) begin
            nx.intr           = '0;
            nx.status[ST_TC]  = 1'b0;
            nx.status[ST_INT] = 1'b0;
            nx.seq            = SEQ_DONE;
        end
        if (wr_go) begin
            case (reg_idx)
                IDX_CNT_LO:  begin nx.cnt_lo  = wr_data; nx.status[ST_TC] = 1'b0; end
                IDX_CNT_MID: begin nx.cnt_mid = wr_data; nx.status[ST_TC] = 1'b0; end
                IDX_CNT_HI:  begin
                    nx.cnt_hi = wr_data;
                    nx.hi_written = 1'b1;
                    nx.status[ST_TC] = 1'b0;
                end
                IDX_CONF1: nx.conf1 = wr_data;
                IDX_CONF2: nx.conf2 = wr_data;
                IDX_CONF3: nx.conf3 = wr_data;
                IDX_CMD: if (act.known) begin
                    if (act.load_intr) nx.intr  = act.intr_val;
                    if (act.clr_seq)   nx.seq   = '0;
                    if (act.clr_flags) nx.flags = '0;
                    if (act.pad)       nx.status = (nx.status & INT_MASK) | TC_MASK;
                    if (raise_cmd)     nx.status[ST_INT] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // The interrupt line is kept as its own flop, driven by the same events.
    always_comb begin
        irq_nx = irq_q;
        if (evt_valid) irq_nx = 1'b1;
        if (rd_intr)   irq_nx = 1'b0;
        if (raise_cmd) irq_nx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_reset) begin
            regs_q <= regs_reset();
            irq_q  <= 1'b0;
        end else begin
            regs_q <= nx;
            irq_q  <= irq_nx;
        end
    end
endmodule

// File: rtl/hfe_front_end.sv
module hfe_front_end
    import hfe_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         REG_SHIFT = 2,
    parameter logic [7:0] CHIP_ID   = 8'hA2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              acc_word,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              evt_valid,
    input  logic [7:0]        evt_intr,
    input  logic [7:0]        evt_status,
    input  logic [7:0]        evt_seq,
    input  logic [7:0]        evt_flags,
    output logic              irq
);
    logic [IDX_W-1:0] reg_idx;
    logic             wr_go, rd_go;
    cmd_act_t         act;
    hfe_regs_t        regs_q;
    logic             irq_q;

    hfe_addr_decode #(.ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT)) u_dec (
        .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en), .acc_word(acc_word),
        .reg_idx(reg_idx), .wr_go(wr_go), .rd_go(rd_go)
    );

    hfe_cmd_decode u_cmd (.cmd_byte(wr_data), .act(act));

    hfe_reg_state u_state (
        .clk(clk), .rst(rst), .ext_reset(ext_reset),
        .wr_go(wr_go), .rd_go(rd_go), .reg_idx(reg_idx), .wr_data(wr_data),
        .act(act), .evt_valid(evt_valid), .evt_intr(evt_intr),
        .evt_status(evt_status), .evt_seq(evt_seq), .evt_flags(evt_flags),
        .regs_q(regs_q), .irq_q(irq_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_go) begin
            case (reg_idx)
                IDX_CNT_LO:  rd_data = regs_q.cnt_lo;
                IDX_CNT_MID: rd_data = regs_q.cnt_mid;
                IDX_CNT_HI:  rd_data = regs_q.hi_written ? regs_q.cnt_hi : CHIP_ID;
                IDX_STATUS:  rd_data = regs_q.status;
                IDX_INTR:    rd_data = regs_q.intr;
                IDX_SEQ:     rd_data = regs_q.seq;
                IDX_FLAGS:   rd_data = regs_q.flags;
                IDX_CONF1:   rd_data = regs_q.conf1;
                IDX_CONF2:   rd_data = regs_q.conf2;
                IDX_CONF3:   rd_data = regs_q.conf3;
                default:     rd_data = '0;
            endcase
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/hfe_front_end_checker.sv
module hfe_front_end_checker (
    input logic       clk,
    input logic       rst,
    input logic       ext_reset,
    input logic       wr_go,
    input logic       rd_go,
    input logic [3:0] reg_idx,
    input logic [7:0] cmd_byte,
    input logic       evt_valid,
    input logic       irq,
    input logic [7:0] st_status,
    input logic [7:0] st_intr,
    input logic [7:0] st_seq,
    input logic [7:0] st_conf1
);
    // R2: line and status INT bit come from separate flops
    p_irq_matches_int_r2: assert property (@(posedge clk) disable iff (rst)
        irq == st_status[7]);

    p_intr_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_go && reg_idx == 4'd5 && !wr_go && !evt_valid && !ext_reset)
        |=> (st_intr == 8'h00 && !irq && st_seq == 8'h04 && !st_status[4]));

    p_hard_reset_r4: assert property (@(posedge clk)
        rst |=> (st_conf1 == 8'h07 && st_intr == 8'h00 && !irq));

    p_ext_reset_r5: assert property (@(posedge clk) disable iff (rst)
        ext_reset |=> (!irq && st_conf1 == 8'h07 && st_status == 8'h00));

    p_busreset_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_go && reg_idx == 4'd3 && (cmd_byte & 8'h7F) == 8'h03 && st_conf1[6]
         && !irq && !evt_valid && !ext_reset)
        |=> (!irq && st_intr == 8'h80));

    p_event_raises_r12: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !rd_go && !wr_go && !ext_reset) |=> irq);

    p_idle_stable_r13: assert property (@(posedge clk) disable iff (rst)
        (!wr_go && !rd_go && !evt_valid && !ext_reset)
        |=> ($stable(irq) && $stable(st_intr) && $stable(st_status)));
endmodule

bind hfe_front_end hfe_front_end_checker u_chk (
    .clk(clk), .rst(rst), .ext_reset(ext_reset),
    .wr_go(wr_go), .rd_go(rd_go), .reg_idx(reg_idx), .cmd_byte(wr_data),
    .evt_valid(evt_valid), .irq(irq),
    .st_status(regs_q.status), .st_intr(regs_q.intr),
    .st_seq(regs_q.seq), .st_conf1(regs_q.conf1)
);

// File: tb/hfe_front_end_test.sv
module hfe_front_end_test;
    localparam int         ADDR_W = 8;
    localparam int         SHIFT  = 2;
    localparam logic [7:0] ID     = 8'hA2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ext_reset = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic             wr_en = 1'b0, rd_en = 1'b0, acc_word = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic             evt_valid = 1'b0;
    logic [7:0]       evt_intr = '0, evt_status = '0, evt_seq = '0, evt_flags = '0;
    logic             irq;

    int checks = 0;
    int fails  = 0;
    int irq_rises = 0;
    bit done = 0;

    typedef struct { logic [7:0] exp; string tag; } exp_item_t;
    exp_item_t sb[$];

    always #4 clk = ~clk;

    hfe_front_end #(.ADDR_W(ADDR_W), .REG_SHIFT(SHIFT), .CHIP_ID(ID)) uut (
        .clk(clk), .rst(rst), .ext_reset(ext_reset), .bus_addr(bus_addr),
        .wr_en(wr_en), .rd_en(rd_en), .acc_word(acc_word), .wr_data(wr_data),
        .rd_data(rd_data), .evt_valid(evt_valid), .evt_intr(evt_intr),
        .evt_status(evt_status), .evt_seq(evt_seq), .evt_flags(evt_flags),
        .irq(irq)
    );

    always @(posedge irq) irq_rises++;

    task automatic check_eq(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a read is on the bus.
    always begin
        @(negedge clk);
        #3;
        if (rd_en) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                check_eq(rd_data, it.exp, it.tag);
            end
        end
    end

    task automatic wr_raw(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit word);
        @(negedge clk);
        bus_addr = a; wr_data = d; acc_word = word; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; acc_word = 1'b0;
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] d);
        wr_raw(ADDR_W'(idx << SHIFT), d, 1'b0);
    endtask

    task automatic rd_raw(input logic [ADDR_W-1:0] a, input logic [7:0] exp,
                          input bit word, input string tag);
        exp_item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        bus_addr = a; acc_word = word; rd_en = 1'b1;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0; acc_word = 1'b0;
    endtask

    task automatic rd_reg(input int idx, input logic [7:0] exp, input string tag);
        rd_raw(ADDR_W'(idx << SHIFT), exp, 1'b0, tag);
    endtask

    task automatic event_in(input logic [7:0] i, input logic [7:0] s,
                            input logic [7:0] q, input logic [7:0] f);
        @(negedge clk);
        evt_intr = i; evt_status = s; evt_seq = q; evt_flags = f; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #3;
        check_eq({7'd0, irq}, {7'd0, exp}, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_irq(1'b0, "R4 irq low after reset");
        rd_reg(8, 8'h07, "R4 conf1 reset value");
        rd_reg(5, 8'h00, "R4 reason reset value");
        rd_reg(4, 8'h00, "R4 status reset value");
        rd_reg(2, ID,    "R11 identifier before write");

        wr_reg(9, 8'h5A);
        rd_reg(9, 8'h5A, "R14 conf2 readback");
        wr_raw(ADDR_W'(10 << SHIFT), 8'h3C, 1'b1);
        rd_reg(10, 8'h3C, "R1 word write accepted");
        rd_raw(ADDR_W'((8 << SHIFT) | 3), 8'h07, 1'b0, "R1 low address bits dropped");

        event_in(8'h18, 8'h13, 8'h03, 8'h02);
        chk_irq(1'b1, "R12 event raises irq");
        rd_reg(4, 8'h93, "R12 status loaded");
        rd_reg(6, 8'h03, "R12 seq loaded");
        rd_reg(7, 8'h02, "R12 flags loaded");
        check_eq(8'(irq_rises), 8'd1, "R2 one rising edge");

        rd_raw(ADDR_W'(5 << SHIFT), 8'h00, 1'b1, "R1 word read returns zero");
        chk_irq(1'b1, "R1 word read no side effect");

        event_in(8'h10, 8'h11, 8'h01, 8'h02);
        chk_irq(1'b1, "R2 irq held");
        check_eq(8'(irq_rises), 8'd1, "R2 no re-raise edge");

        rd_reg(5, 8'h10, "R3 read returns old reason");
        chk_irq(1'b0, "R3 irq cleared by read");
        rd_reg(5, 8'h00, "R3 reason cleared");
        rd_reg(4, 8'h01, "R3 status INT and TC cleared");
        rd_reg(6, 8'h04, "R3 seq set to done");

        event_in(8'h10, 8'h10, 8'h03, 8'h05);
        wr_reg(0, 8'h11);
        rd_reg(4, 8'h80, "R11 count write clears TC");
        rd_reg(0, 8'h11, "R11 count low readback");
        rd_reg(2, ID,    "R11 identifier still shown");
        wr_reg(2, 8'h77);
        rd_reg(2, 8'h77, "R11 written value after write");
        rd_reg(5, 8'h10, "R3 reason read");

        wr_reg(3, 8'h01);
        chk_irq(1'b0, "R7 flush no irq");
        rd_reg(7, 8'h00, "R7 flush clears flags");
        rd_reg(6, 8'h00, "R7 flush clears seq");
        rd_reg(5, 8'h08, "R7 flush reason");

        wr_reg(3, 8'h92);
        chk_irq(1'b1, "R8 message accept raises, R13 bit 7 ignored");
        rd_reg(6, 8'h00, "R8 message accept clears seq");
        rd_reg(5, 8'h20, "R8 message accept reason");
        chk_irq(1'b0, "R3 irq cleared");

        wr_reg(3, 8'h01);
        wr_reg(3, 8'h44);
        chk_irq(1'b0, "R9 enable select no irq");
        rd_reg(5, 8'h00, "R9 enable select clears reason");
        wr_reg(3, 8'h01);
        wr_reg(3, 8'h45);
        chk_irq(1'b1, "R9 disable select raises");
        rd_reg(5, 8'h00, "R9 disable select clears reason");
        chk_irq(1'b0, "R3 irq cleared");

        event_in(8'h10, 8'h00, 8'h02, 8'h00);
        wr_reg(3, 8'h18);
        chk_irq(1'b1, "R10 pad keeps irq");
        rd_reg(4, 8'h90, "R10 pad status");
        rd_reg(6, 8'h00, "R10 pad clears seq");
        rd_reg(5, 8'h08, "R10 pad reason");
        chk_irq(1'b0, "R3 irq cleared");

        wr_reg(3, 8'h03);
        chk_irq(1'b1, "R6 bus reset raises");
        rd_reg(5, 8'h80, "R6 bus reset reason");
        wr_reg(8, 8'h47);
        wr_reg(3, 8'h03);
        chk_irq(1'b0, "R6 masked bus reset");
        rd_reg(5, 8'h80, "R6 masked bus reset reason");
        wr_reg(8, 8'h07);

        event_in(8'h18, 8'h02, 8'h01, 8'h00);
        wr_reg(3, 8'h33);
        wr_reg(12, 8'hFF);
        wr_reg(4, 8'hFF);
        wr_reg(5, 8'h00);
        chk_irq(1'b1, "R13 irq unchanged");
        rd_reg(4, 8'h82, "R13 status unchanged");
        rd_reg(12, 8'h00, "R13 undefined index reads zero");
        rd_reg(6, 8'h01, "R13 seq unchanged");
        rd_reg(5, 8'h18, "R13 reason unchanged");

        event_in(8'h18, 8'h00, 8'h00, 8'h00);
        wr_reg(3, 8'h02);
        chk_irq(1'b0, "R5 soft reset lowers irq");
        rd_reg(9, 8'h00, "R5 conf2 cleared");
        rd_reg(8, 8'h07, "R5 conf1 reset value");
        rd_reg(2, ID,    "R5 identifier back");
        rd_reg(4, 8'h00, "R5 status cleared");

        wr_reg(10, 8'h11);
        event_in(8'h18, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        ext_reset = 1'b1;
        @(negedge clk);
        ext_reset = 1'b0;
        chk_irq(1'b0, "R5 external reset lowers irq");
        rd_reg(10, 8'h00, "R5 external reset clears conf3");
        rd_reg(5, 8'h00, "R5 external reset clears reason");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule